// File: doc/BRIEF.md
# Two-Cycle Processor Core with Control Unit

The block is a compact 32-bit processor core. A control unit steps through two phases for every instruction: a fetch phase that copies the word at the program counter into the instruction register, and an execute phase that decodes that word, performs the operation, updates the condition flags and moves the program counter. The core talks to one word-addressed memory through a single port. Both instruction fetches and data accesses use it. Read data must be valid in the same cycle the address is presented, and writes take effect at the clock edge that ends the cycle.

The instruction set covers the following operations:
- register add
- add of a sign-extended 8-bit constant
- compare
- word load and store through a base register
- relative branches, either unconditional or gated on the flags

Each 32-bit instruction word is laid out as follows:
- opcode in bits [31:28]
- destination register, or branch condition, in bits [27:24]
- first source register in bits [23:20]
- second source register in bits [19:16]
- immediate in bits [7:0]
- branch offset in bits [23:0]

Top module: `cpu_core`

## Requirements
- R1: While reset is asserted and in the first cycle after release, the port shows a fetch: address 0x8000, write enable low. Every register and the status word are cleared.
- R2: Phases alternate strictly, fetch then execute. In a fetch cycle the address is the program counter, write enable is low and write data is zero. Every instruction takes exactly two cycles.
- R3: Opcode 1 (add) writes Rd = Rn + Rm, updates the flags and advances the program counter by one.
- R4: The status word holds N in bit 31, Z in bit 30, C in bit 29 and V in bit 28. N is the result MSB. Z is set for a zero result. C is the adder carry-out. V is signed overflow. Bits 27:0 read zero.
- R5: Opcode 2 (add immediate) adds the sign-extended bits [7:0] to Rn, writes Rd, updates the flags and advances the program counter by one.
- R6: Opcode 3 (compare) computes Rn - Rm as Rn + ~Rm + 1, so C=1 means no borrow. It updates the flags, writes no register and advances the program counter by one.
- R7: Opcode 4 (load) places Rn on the address in the execute cycle with write enable low, writes the returned word into Rd and advances the program counter by one.
- R8: Opcode 5 (store) places Rn on the address, Rd on the write data and raises write enable in the execute cycle only. It advances the program counter by one.
- R9: Opcode 6 (branch) reads its condition from bits [27:24]: 0 taken when Z=1, 1 when Z=0, 2 when N!=V, 3 when N==V, 4 always, any other code never. A taken branch adds the sign-extended bits [23:0] to the program counter. A branch not taken adds one.
- R10: Opcodes 0 and 7 to 15 write no register, no flag and no memory, and only advance the program counter by one.
- R11: Only add, add immediate and compare change the flags. Load, store, branch and undefined opcodes leave them as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 32 | Word address for fetch or data access |
| mem_we_o | output | 1 | Write enable, high only during a store execute cycle |
| mem_wdata_o | output | 32 | Store data, zero when not writing |
| mem_rdata_i | input | 32 | Word read from the addressed location, valid in the same cycle |

## Verification
The hardest state to reach from the ports is a flag combination that separates the signed conditions. One example is N and V both set with Z clear, where "less than" and "greater or equal" must disagree with what the sign bit alone suggests. Flags cannot be read directly, so the stimulus loads 0x7FFFFFFF from data memory and adds one to force signed overflow. It then compares zero with the most negative value, and lets the next fetch address reveal which branches were taken. The same program runs a five-element summation loop whose exit depends on Z after a decrement with carry-out. It also places skipped stores behind taken branches, so a wrong branch decision shows up as a corrupted result word.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  localparam int INSTR_W = 32;

  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_ADDI = 4'd2;
  localparam logic [3:0] OP_CMP  = 4'd3;
  localparam logic [3:0] OP_LDR  = 4'd4;
  localparam logic [3:0] OP_STR  = 4'd5;
  localparam logic [3:0] OP_BR   = 4'd6;

  localparam logic [3:0] CC_EQ = 4'd0;
  localparam logic [3:0] CC_NE = 4'd1;
  localparam logic [3:0] CC_LT = 4'd2;
  localparam logic [3:0] CC_GE = 4'd3;
  localparam logic [3:0] CC_AL = 4'd4;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } phase_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic rf_we;
    logic flag_we;
    logic use_imm;
    logic sub;
    logic mem_rd;
    logic mem_wr;
    logic branch;
  } ctrl_t;

  function automatic logic op_sets_flags(logic [3:0] op);
    return (op == OP_ADD) || (op == OP_ADDI) || (op == OP_CMP);
  endfunction

  function automatic logic op_defined(logic [3:0] op);
    return (op >= OP_ADD) && (op <= OP_BR);
  endfunction

endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int NREG   = 16,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);

  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (we_i && (waddr_i == AW'(g))) begin
        regs_q[g] <= wdata_i;
      end
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output cpu_pkg::flags_t   flags_o
);

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    wide  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
    res_o = wide[DATA_W-1:0];
    flags_o.n = res_o[DATA_W-1];
    flags_o.z = (res_o == '0);
    flags_o.c = wide[DATA_W];
    // overflow: operands agree in sign, result does not
    flags_o.v = (a_i[DATA_W-1] == b_eff[DATA_W-1]) &&
                (res_o[DATA_W-1] != a_i[DATA_W-1]);
  end

endmodule

// File: rtl/cpu_decode.sv
module cpu_decode #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int OFF_W  = 24
) (
  input  logic [cpu_pkg::INSTR_W-1:0] ir_i,
  input  cpu_pkg::flags_t             flags_i,
  output cpu_pkg::ctrl_t              ctrl_o,
  output logic [3:0]                  rd_o,
  output logic [3:0]                  rn_o,
  output logic [3:0]                  rm_o,
  output logic [DATA_W-1:0]           imm_o,
  output logic [DATA_W-1:0]           off_o,
  output logic                        taken_o
);
  import cpu_pkg::*;

  logic [3:0] op;
  logic [3:0] cc;
  logic       cond_ok;

  assign op    = ir_i[31:28];
  assign rd_o  = ir_i[27:24];
  assign cc    = ir_i[27:24];
  assign rn_o  = ir_i[23:20];
  assign rm_o  = ir_i[19:16];
  assign imm_o = {{(DATA_W-IMM_W){ir_i[IMM_W-1]}}, ir_i[IMM_W-1:0]};
  assign off_o = {{(DATA_W-OFF_W){ir_i[OFF_W-1]}}, ir_i[OFF_W-1:0]};

  always_comb begin
    ctrl_o = '0;
    unique case (op)
      OP_ADD:  begin ctrl_o.rf_we = 1'b1; ctrl_o.flag_we = 1'b1; end
      OP_ADDI: begin ctrl_o.rf_we = 1'b1; ctrl_o.flag_we = 1'b1; ctrl_o.use_imm = 1'b1; end
      OP_CMP:  begin ctrl_o.flag_we = 1'b1; ctrl_o.sub = 1'b1; end
      OP_LDR:  begin ctrl_o.rf_we = 1'b1; ctrl_o.mem_rd = 1'b1; end
      OP_STR:  ctrl_o.mem_wr = 1'b1;
      OP_BR:   ctrl_o.branch = 1'b1;
      default: ctrl_o = '0;
    endcase
  end

  always_comb begin
    unique case (cc)
      CC_EQ:   cond_ok = flags_i.z;
      CC_NE:   cond_ok = !flags_i.z;
      CC_LT:   cond_ok = flags_i.n != flags_i.v;
      CC_GE:   cond_ok = flags_i.n == flags_i.v;
      CC_AL:   cond_ok = 1'b1;
      default: cond_ok = 1'b0;
    endcase
  end

  assign taken_o = ctrl_o.branch && cond_ok;

endmodule

// File: rtl/cpu_core.sv
module cpu_core #(
  parameter int          DATA_W   = 32,
  parameter int          NREG     = 16,
  parameter int          IMM_W    = 8,
  parameter int          OFF_W    = 24,
  parameter logic [31:0] RESET_PC = 32'h0000_8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  import cpu_pkg::*;

  localparam int FLAG_LSB = DATA_W - 4;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  phase_e            phase_q;
  logic [DATA_W-1:0] pc_q;
  logic [INSTR_W-1:0] ir_q;
  logic [DATA_W-1:0] psr_q;

  ctrl_t             ctrl;
  logic [3:0]        rd, rn, rm;
  logic [DATA_W-1:0] imm_ext, off_ext;
  logic              taken;
  flags_t            cur_flags, alu_flags;
  logic [DATA_W-1:0] rdata_a, rdata_b, alu_b, alu_res;
  logic              exec, rf_we;
  logic [DATA_W-1:0] rf_wdata, pc_next;

  assign exec      = (phase_q == PH_EXEC);
  assign cur_flags = psr_q[DATA_W-1:FLAG_LSB];

  cpu_decode #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .OFF_W  (OFF_W)
  ) i_decode (
    .ir_i    (ir_q),
    .flags_i (cur_flags),
    .ctrl_o  (ctrl),
    .rd_o    (rd),
    .rn_o    (rn),
    .rm_o    (rm),
    .imm_o   (imm_ext),
    .off_o   (off_ext),
    .taken_o (taken)
  );

  assign rf_we    = exec && ctrl.rf_we;
  assign rf_wdata = ctrl.mem_rd ? mem_rdata_i : alu_res;

  // port b carries Rd for stores
  cpu_regfile #(
    .NREG   (NREG),
    .DATA_W (DATA_W)
  ) i_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (rd),
    .wdata_i   (rf_wdata),
    .raddr_a_i (rn),
    .rdata_a_o (rdata_a),
    .raddr_b_i (ctrl.mem_wr ? rd : rm),
    .rdata_b_o (rdata_b)
  );

  assign alu_b = ctrl.use_imm ? imm_ext : rdata_b;

  cpu_alu #(
    .DATA_W (DATA_W)
  ) i_alu (
    .a_i     (rdata_a),
    .b_i     (alu_b),
    .sub_i   (ctrl.sub),
    .res_o   (alu_res),
    .flags_o (alu_flags)
  );

  assign mem_addr_o  = (exec && (ctrl.mem_rd || ctrl.mem_wr)) ? rdata_a : pc_q;
  assign mem_we_o    = exec && ctrl.mem_wr;
  assign mem_wdata_o = mem_we_o ? rdata_b : '0;

  assign pc_next = taken ? (pc_q + off_ext) : (pc_q + ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FETCH;
      pc_q    <= DATA_W'(RESET_PC);
      ir_q    <= '0;
      psr_q   <= '0;
    end else if (!exec) begin
      ir_q    <= mem_rdata_i;
      phase_q <= PH_EXEC;
    end else begin
      pc_q    <= pc_next;
      phase_q <= PH_FETCH;
      if (ctrl.flag_we) psr_q[DATA_W-1:FLAG_LSB] <= alu_flags;
    end
  end

endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk #(
  parameter int DATA_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input cpu_pkg::phase_e    phase_q,
  input logic [DATA_W-1:0]  pc_q,
  input logic [DATA_W-1:0]  psr_q,
  input logic [31:0]        ir_q,
  input logic               rf_we,
  input logic               mem_we_o,
  input logic [DATA_W-1:0]  mem_addr_o
);
  import cpu_pkg::*;

  logic       exec;
  logic [3:0] op;
  assign exec = (phase_q == PH_EXEC);
  assign op   = ir_q[31:28];

  a_r2_phase_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> phase_q != $past(phase_q));

  a_r2_fetch_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec |-> (mem_addr_o == pc_q) && !mem_we_o);

  a_r2_fetch_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec |=> pc_q == $past(pc_q));

  a_r8_write_only_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> exec && (op == OP_STR));

  a_r6_cmp_no_reg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && op == OP_CMP) |-> !rf_we);

  a_r11_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && !op_sets_flags(op)) |=> psr_q == $past(psr_q));

  a_r10_undef_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && !op_defined(op)) |=> pc_q == $past(pc_q) + DATA_W'(1));

  a_r10_undef_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && !op_defined(op)) |-> !rf_we && !mem_we_o);

  a_r4_psr_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psr_q[DATA_W-5:0] == '0);

endmodule

bind cpu_core cpu_core_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .phase_q    (phase_q),
  .pc_q       (pc_q),
  .psr_q      (psr_q),
  .ir_q       (ir_q),
  .rf_we      (rf_we),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/test_cpu_core.sv
module test_cpu_core;

  localparam int CLK_PERIOD = 10;
  localparam int NCYC       = 160;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;

  logic [31:0] mem  [256];
  logic [31:0] mref [256];

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [31:0] q_addr[$];
  logic        q_we[$];
  logic [31:0] q_wdata[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int idx(logic [31:0] a);
    return int'({a[15], a[6:0]});
  endfunction

  assign mem_rdata = mem[idx(mem_addr)];

  always @(posedge clk) if (mem_we) mem[idx(mem_addr)] <= mem_wdata;

  cpu_core i_cpu_core (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (mem_addr),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata)
  );

  function automatic logic [31:0] e_r(logic [3:0] op, logic [3:0] rd, logic [3:0] rn, logic [3:0] rm);
    return {op, rd, rn, rm, 16'h0000};
  endfunction
  function automatic logic [31:0] e_i(logic [3:0] op, logic [3:0] rd, logic [3:0] rn, logic [7:0] imm);
    return {op, rd, rn, 12'h000, imm};
  endfunction
  function automatic logic [31:0] e_b(logic [3:0] cc, int off);
    logic [31:0] o = 32'(off);
    return {4'h6, cc, o[23:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // reference model producing the expected port activity per cycle
  task automatic build_expected();
    logic [31:0] r [16];
    logic [31:0] pc, ir, a, b, res;
    logic [3:0]  op, rd, rn, rm, cc;
    logic        n, z, c, v, sub, tk;
    logic [32:0] w;
    bit          ph;
    string       prev;
    for (int i = 0; i < 16; i++) r[i] = '0;
    pc = 32'h8000; n = 0; z = 0; c = 0; v = 0; ph = 0; ir = '0; prev = "R1";
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      if (!ph) begin
        q_addr.push_back(pc); q_we.push_back(0); q_wdata.push_back(0);
        q_tag.push_back({"R2 fetch after ", prev});
        ir = mref[idx(pc)];
        ph = 1;
      end else begin
        op = ir[31:28]; rd = ir[27:24]; rn = ir[23:20]; rm = ir[19:16]; cc = ir[27:24];
        ph = 0;
        case (op)
          4'd1, 4'd2, 4'd3: begin
            sub = (op == 4'd3);
            a = r[rn];
            b = (op == 4'd2) ? {{24{ir[7]}}, ir[7:0]} : r[rm];
            if (sub) b = ~b;
            w = {1'b0, a} + {1'b0, b} + {32'd0, sub};
            res = w[31:0];
            n = res[31]; z = (res == 0); c = w[32];
            v = (a[31] == b[31]) && (res[31] != a[31]);
            if (!sub) r[rd] = res;
            q_addr.push_back(pc); q_we.push_back(0); q_wdata.push_back(0);
            prev = (op == 4'd1) ? "R3 R4" : (op == 4'd2) ? "R5 R4" : "R6 R4";
            q_tag.push_back(prev);
            pc = pc + 1;
          end
          4'd4: begin
            q_addr.push_back(r[rn]); q_we.push_back(0); q_wdata.push_back(0);
            prev = "R7"; q_tag.push_back(prev);
            r[rd] = mref[idx(r[rn])];
            pc = pc + 1;
          end
          4'd5: begin
            q_addr.push_back(r[rn]); q_we.push_back(1); q_wdata.push_back(r[rd]);
            prev = "R8"; q_tag.push_back(prev);
            mref[idx(r[rn])] = r[rd];
            pc = pc + 1;
          end
          4'd6: begin
            case (cc)
              4'd0: tk = z;
              4'd1: tk = !z;
              4'd2: tk = (n != v);
              4'd3: tk = (n == v);
              4'd4: tk = 1;
              default: tk = 0;
            endcase
            q_addr.push_back(pc); q_we.push_back(0); q_wdata.push_back(0);
            prev = "R9 R4 R11"; q_tag.push_back(prev);
            pc = tk ? pc + {{8{ir[23]}}, ir[23:0]} : pc + 1;
          end
          default: begin
            q_addr.push_back(pc); q_we.push_back(0); q_wdata.push_back(0);
            prev = "R10 R11"; q_tag.push_back(prev);
            pc = pc + 1;
          end
        endcase
      end
    end
  endtask

  task automatic load_program();
    logic [31:0] p [32];
    for (int i = 0; i < 256; i++) mem[i] = '0;
    p[0]  = e_i(4'd2, 4'd1, 4'd0, 8'h10);
    p[1]  = e_i(4'd2, 4'd2, 4'd0, 8'h05);
    p[2]  = e_i(4'd2, 4'd3, 4'd0, 8'h00);
    p[3]  = e_i(4'd2, 4'd4, 4'd0, 8'hFF);
    p[4]  = e_r(4'd4, 4'd5, 4'd1, 4'd0);
    p[5]  = e_r(4'd1, 4'd3, 4'd3, 4'd5);
    p[6]  = e_i(4'd2, 4'd1, 4'd1, 8'h01);
    p[7]  = e_r(4'd1, 4'd2, 4'd2, 4'd4);
    p[8]  = e_b(4'd1, -4);
    p[9]  = e_i(4'd2, 4'd6, 4'd0, 8'h20);
    p[10] = e_r(4'd5, 4'd3, 4'd6, 4'd0);
    p[11] = e_r(4'd3, 4'd0, 4'd3, 4'd3);
    p[12] = e_b(4'd0, 2);
    p[13] = e_r(4'd5, 4'd0, 4'd6, 4'd0);
    p[14] = 32'hF712_3456;
    p[15] = e_b(4'd1, 5);
    p[16] = e_i(4'd2, 4'd9, 4'd0, 8'h30);
    p[17] = e_r(4'd4, 4'd10, 4'd9, 4'd0);
    p[18] = e_i(4'd2, 4'd11, 4'd10, 8'h01);
    p[19] = e_b(4'd2, 5);
    p[20] = e_b(4'd3, 2);
    p[21] = e_r(4'd5, 4'd0, 4'd6, 4'd0);
    p[22] = e_r(4'd3, 4'd0, 4'd0, 4'd11);
    p[23] = e_b(4'd3, 2);
    p[24] = e_r(4'd5, 4'd0, 4'd6, 4'd0);
    p[25] = e_i(4'd2, 4'd12, 4'd0, 8'hFF);
    p[26] = e_r(4'd1, 4'd13, 4'd12, 4'd12);
    p[27] = e_r(4'd5, 4'd13, 4'd9, 4'd0);
    p[28] = 32'h0000_0000;
    p[29] = e_b(4'd9, 3);
    p[30] = e_b(4'd4, 0);
    p[31] = 32'h0000_0000;
    for (int i = 0; i < 32; i++) mem[idx(32'h8000 + 32'(i))] = p[i];
    mem[idx(32'h10)] = 32'd3;
    mem[idx(32'h11)] = 32'd10;
    mem[idx(32'h12)] = 32'hFFFF_FFFE;
    mem[idx(32'h13)] = 32'd100;
    mem[idx(32'h14)] = 32'd7;
    mem[idx(32'h30)] = 32'h7FFF_FFFF;
    for (int i = 0; i < 256; i++) mref[i] = mem[i];
  endtask

  // driver
  initial begin
    load_program();
    build_expected();
    repeat (3) @(negedge clk);
    check("R1 reset address", mem_addr, 32'h8000);
    check("R1 reset write enable", {31'd0, mem_we}, 32'd0);
    @(posedge clk);
    #1 rst_n = 1'b1;
  end

  // monitor
  initial begin
    @(posedge rst_n);
    while (q_addr.size() > 0) begin
      logic [31:0] ea, ed;
      logic        ew;
      string       t;
      @(negedge clk);
      ea = q_addr.pop_front(); ew = q_we.pop_front();
      ed = q_wdata.pop_front(); t = q_tag.pop_front();
      check({t, " address"}, mem_addr, ea);
      check({t, " write enable"}, {31'd0, mem_we}, {31'd0, ew});
      check({t, " write data"}, mem_wdata, ed);
    end
    @(negedge clk);
    check("R3 R8 loop sum stored, skipped stores absent (R9)", mem[idx(32'h20)], 32'd118);
    check("R3 R4 carry wrap result stored", mem[idx(32'h30)], 32'hFFFF_FFFE);
    check("R7 source data untouched", mem[idx(32'h12)], 32'hFFFF_FFFE);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

endmodule